// File: doc/BRIEF.md
# Pixel PLL Reprogramming Sequencer

This block owns the 64-bit control image that drives the pins of a pixel-clock PLL and walks that image through a safe retune. The host gives one start pulse together with a new output divider, feedback multiplier and input divider. The block then applies a fixed chain of single-field read-modify-write steps to the image. Each step takes one clock.

The chain runs as follows. The PLL is bypassed and its output is gated. It is powered down. The update strobe is raised, the three ratio fields are loaded, and the strobe is dropped. Power is then restored. Next the block waits a settle interval counted in system clocks. It then samples the PLL lock input once per cycle, up to a capped number of samples. After that it enables the output and leaves bypass. This happens even when lock never arrived, and in that case a sticky timeout flag is raised.

A one-cycle done pulse marks the end of the chain. The image starts out powered down and bypassed.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the image holds only bypass (bit 44) and powerdown (bit 45) set, and busy, done and timeout are all low.
- R2: A run loads the output divider into bits 6:0, the multiplier into bits 29:21 and the input divider into bits 38:32, using the values captured with the accepted start.
- R3: The first seven clocks after the start is accepted change the image one step each, in this order: set bit 44, clear bit 40, set bit 45, set bit 43, load the three ratio fields, clear bit 43, clear bit 45. Every other bit keeps its previous value.
- R4: After powerup the block waits CYC_PER_US*SETTLE_US clocks before the first lock sample, and takes one lock sample per clock. The done pulse follows the edge that accepted the start by 9 + settle + samples edges.
- R5: Lock is sampled at most POLL_MAX times. If no sample sees lock, the chain still completes, and timeout rises.
- R6: Timeout stays high while the block is idle and is cleared when the next start is accepted.
- R7: A start pulse while busy is high is ignored and changes neither the loaded values nor the timing.
- R8: done is high for exactly one clock. At that point the image has output select (bit 40) set and bypass, powerdown and update strobe cleared, and busy then reads low.
- R9: Bit 39 and all reserved bits of the image (every bit outside 6:0, 29:21, 38:32, 40, 43, 44, 45) are always zero.
- R10: The update strobe is only ever set while powerdown is set, and output select is never set while powerdown is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; the ratio inputs are captured with it |
| odiv_i | input | 7 | New output divider |
| mult_i | input | 9 | New feedback multiplier |
| idiv_i | input | 7 | New input divider |
| lock_i | input | 1 | Lock indicator from the PLL |
| ctrl_o | output | 64 | Control image driving the PLL pins |
| busy_o | output | 1 | High from start acceptance until done |
| done_o | output | 1 | One-cycle end-of-run pulse |
| timeout_o | output | 1 | Sticky flag: the last run never saw lock |

## Verification
If the state register skips or repeats a step, the image sampled after each of the first seven edges differs from the expected one at that same edge. A wrong settle or poll count is visible as a done pulse arriving on the wrong edge, and the bench times that edge exactly for no-wait, mid-window and never-lock PLL responses. A timer that fails to stop shows up as a stuck busy, caught within a few thousand cycles. A corrupted field update shows up either in a reserved bit or in the final ratio fields. Both are checked as soon as done is seen.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   localparam int IMG_W    = 64;
   localparam int ODIV_LSB = 0;
   localparam int ODIV_W   = 7;
   localparam int MULT_LSB = 21;
   localparam int MULT_W   = 9;
   localparam int IDIV_LSB = 32;
   localparam int IDIV_W   = 7;
   localparam int LOCK_BIT = 39;
   localparam int OSEL_BIT = 40;
   localparam int TRIG_BIT = 43;
   localparam int BYP_BIT  = 44;
   localparam int PDN_BIT  = 45;

   typedef enum logic [3:0] {
      ST_IDLE, ST_BYP, ST_GATE, ST_PDN, ST_TRIG, ST_LOAD, ST_UNTRIG,
      ST_PUP, ST_SETTLE, ST_POLL, ST_ENOUT, ST_UNBYP
   } seq_st_e;

   function automatic logic [IMG_W-1:0] used_mask();
      logic [IMG_W-1:0] m;
      m = '0;
      for (int i = 0; i < ODIV_W; i++) m[ODIV_LSB+i] = 1'b1;
      for (int i = 0; i < MULT_W; i++) m[MULT_LSB+i] = 1'b1;
      for (int i = 0; i < IDIV_W; i++) m[IDIV_LSB+i] = 1'b1;
      m[OSEL_BIT] = 1'b1;
      m[TRIG_BIT] = 1'b1;
      m[BYP_BIT]  = 1'b1;
      m[PDN_BIT]  = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             last_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/pll_seq_image.sv
module pll_seq_image
   import pll_seq_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  seq_st_e                   step_i,
   input  logic [ODIV_W-1:0]         odiv_i,
   input  logic [MULT_W-1:0]         mult_i,
   input  logic [IDIV_W-1:0]         idiv_i,
   output logic [IMG_W-1:0]          img_o
);
   logic [IMG_W-1:0] img_q, img_d;

   always_comb begin
      img_d = img_q;
      unique case (step_i)
         ST_BYP:    img_d[BYP_BIT]  = 1'b1;
         ST_GATE:   img_d[OSEL_BIT] = 1'b0;
         ST_PDN:    img_d[PDN_BIT]  = 1'b1;
         ST_TRIG:   img_d[TRIG_BIT] = 1'b1;
         ST_LOAD: begin
            img_d[ODIV_LSB +: ODIV_W] = odiv_i;
            img_d[MULT_LSB +: MULT_W] = mult_i;
            img_d[IDIV_LSB +: IDIV_W] = idiv_i;
         end
         ST_UNTRIG: img_d[TRIG_BIT] = 1'b0;
         ST_PUP:    img_d[PDN_BIT]  = 1'b0;
         ST_ENOUT:  img_d[OSEL_BIT] = 1'b1;
         ST_UNBYP:  img_d[BYP_BIT]  = 1'b0;
         default:   img_d = img_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         img_q          <= '0;
         img_q[BYP_BIT] <= 1'b1;
         img_q[PDN_BIT] <= 1'b1;
      end else begin
         img_q <= img_d;
      end
   end

   assign img_o = img_q;
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int CYC_PER_US = 100,
   parameter int SETTLE_US  = 2,
   parameter int POLL_MAX   = 2000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [6:0]  odiv_i,
   input  logic [8:0]  mult_i,
   input  logic [6:0]  idiv_i,
   input  logic        lock_i,
   output logic [63:0] ctrl_o,
   output logic        busy_o,
   output logic        done_o,
   output logic        timeout_o
);
   localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
   localparam int CNT_MAX    = (SETTLE_CYC > POLL_MAX) ? SETTLE_CYC : POLL_MAX;
   localparam int CNT_W      = $clog2(CNT_MAX + 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("settle interval must be at least one clock");
      end
      if (POLL_MAX < 1) begin : g_bad_poll
         $error("POLL_MAX must be at least one");
      end
   endgenerate

   seq_st_e            st_q, st_d;
   logic [ODIV_W-1:0]  odiv_q;
   logic [MULT_W-1:0]  mult_q;
   logic [IDIV_W-1:0]  idiv_q;
   logic               tmo_q, done_q;
   logic               t_clr, t_last;
   logic [CNT_W-1:0]   t_limit;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (start_i) st_d = ST_BYP;
         ST_BYP:    st_d = ST_GATE;
         ST_GATE:   st_d = ST_PDN;
         ST_PDN:    st_d = ST_TRIG;
         ST_TRIG:   st_d = ST_LOAD;
         ST_LOAD:   st_d = ST_UNTRIG;
         ST_UNTRIG: st_d = ST_PUP;
         ST_PUP:    st_d = ST_SETTLE;
         ST_SETTLE: if (t_last) st_d = ST_POLL;
         ST_POLL:   if (lock_i || t_last) st_d = ST_ENOUT;
         ST_ENOUT:  st_d = ST_UNBYP;
         ST_UNBYP:  st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   assign t_limit = (st_q == ST_POLL) ? CNT_W'(POLL_MAX) : CNT_W'(SETTLE_CYC);
   assign t_clr   = !((st_q == ST_SETTLE) || (st_q == ST_POLL)) || (st_d != st_q);

   pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (t_clr),
      .limit_i (t_limit),
      .last_o  (t_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         odiv_q <= '0;
         mult_q <= '0;
         idiv_q <= '0;
         tmo_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q == ST_UNBYP);
         if (st_q == ST_IDLE && start_i) begin
            odiv_q <= odiv_i;
            mult_q <= mult_i;
            idiv_q <= idiv_i;
            tmo_q  <= 1'b0;
         end else if (st_q == ST_POLL && !lock_i && t_last) begin
            tmo_q  <= 1'b1;
         end
      end
   end

   pll_seq_image u_image (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (st_q),
      .odiv_i (odiv_q),
      .mult_i (mult_q),
      .idiv_i (idiv_q),
      .img_o  (ctrl_o)
   );

   assign busy_o    = (st_q != ST_IDLE);
   assign done_o    = done_q;
   assign timeout_o = tmo_q;
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk
   import pll_seq_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic [63:0] ctrl_o,
   input logic        busy_o,
   input logic        done_o,
   input logic        timeout_o
);
   localparam logic [IMG_W-1:0] USED = used_mask();

   assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o & ~USED) == '0);

   assert_trig_in_pdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_o[TRIG_BIT] |-> ctrl_o[PDN_BIT]);

   assert_gate_in_pdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_o[PDN_BIT] |-> !ctrl_o[OSEL_BIT]);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_image_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ctrl_o[OSEL_BIT] && !ctrl_o[BYP_BIT] && !ctrl_o[PDN_BIT]
                  && !ctrl_o[TRIG_BIT] && !busy_o));

   assert_tmo_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o && !start_i) |=> timeout_o);

   assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(ctrl_o));

   assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .ctrl_o    (ctrl_o),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .timeout_o (timeout_o)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
   localparam int NSET = 200;
   localparam int PMAX = 2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [6:0]  odiv_i = '0;
   logic [8:0]  mult_i = '0;
   logic [6:0]  idiv_i = '0;
   logic        lock_i;
   logic [63:0] ctrl_o;
   logic        busy_o, done_o, timeout_o;

   int total = 0;
   int bad = 0;
   int lock_dly = 0;
   int lcnt = 0;
   logic [63:0] exp_img;

   always #5 clk = ~clk;

   pll_reprog_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .odiv_i(odiv_i),
      .mult_i(mult_i), .idiv_i(idiv_i), .lock_i(lock_i), .ctrl_o(ctrl_o),
      .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
   );

   // PLL model: lock rises lock_dly clocks after powerdown is released
   always @(posedge clk) begin
      if (ctrl_o[45]) lcnt <= 0;
      else if (lcnt < 100000) lcnt <= lcnt + 1;
   end
   assign lock_i = !ctrl_o[45] && (lcnt >= lock_dly);

   // odiv, mult, idiv, lock delay
   localparam int NV = 5;
   localparam int VEC [NV][4] = '{
      '{11, 49, 3, 0},
      '{20, 39, 3, NSET + 5},
      '{127, 511, 127, NSET + 200},
      '{8, 95, 4, 9999},
      '{85, 107, 5, 0}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_seq(input int od, input int mu, input int id, input int dly,
                          input bit inject);
      int p;
      int t;
      bit exp_to;
      logic [63:0] prev;
      p = dly - NSET + 1;
      if (p < 1) p = 1;
      exp_to = (p > PMAX);
      if (p > PMAX) p = PMAX;
      lock_dly = dly;
      @(negedge clk);
      start_i = 1'b1; odiv_i = 7'(od); mult_i = 9'(mu); idiv_i = 7'(id);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk(timeout_o == 1'b0, "R6", "timeout cleared on start", 64'(timeout_o), 64'd0);
      for (int s = 1; s <= 7; s++) begin
         prev = exp_img;
         case (s)
            1: exp_img[44] = 1'b1;
            2: exp_img[40] = 1'b0;
            3: exp_img[45] = 1'b1;
            4: exp_img[43] = 1'b1;
            5: begin
               exp_img[6:0] = 7'(od); exp_img[29:21] = 9'(mu); exp_img[38:32] = 7'(id);
            end
            6: exp_img[43] = 1'b0;
            default: exp_img[45] = 1'b0;
         endcase
         if (inject && s == 2) begin
            start_i = 1'b1; odiv_i = 7'd1; mult_i = 9'd2; idiv_i = 7'd3;
         end
         @(posedge clk);
         @(negedge clk);
         start_i = 1'b0;
         chk(ctrl_o == exp_img, "R3", $sformatf("step %0d image", s), ctrl_o, exp_img);
      end
      t = 7;
      while (!done_o && t < 5000) begin
         @(posedge clk); t++;
         @(negedge clk);
      end
      chk(t == 9 + NSET + p, inject ? "R7" : "R4", "done edge count", 64'(t), 64'(9 + NSET + p));
      exp_img[40] = 1'b1; exp_img[44] = 1'b0;
      chk(ctrl_o == exp_img, "R2", "final image fields", ctrl_o, exp_img);
      chk(busy_o == 1'b0, "R8", "busy low at done", 64'(busy_o), 64'd0);
      chk(timeout_o == exp_to, "R5", "timeout after run", 64'(timeout_o), 64'(exp_to));
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R8", "done one cycle", 64'(done_o), 64'd0);
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(timeout_o == exp_to, "R6", "timeout held idle", 64'(timeout_o), 64'(exp_to));
      chk(ctrl_o == exp_img, "R9", "idle image unchanged", ctrl_o, exp_img);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      exp_img = '0;
      exp_img[44] = 1'b1;
      exp_img[45] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ctrl_o == exp_img, "R1", "reset image", ctrl_o, exp_img);
      chk({busy_o, done_o, timeout_o} == 3'b000, "R1", "reset flags",
          64'({busy_o, done_o, timeout_o}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(ctrl_o == exp_img, "R1", "image after reset release", ctrl_o, exp_img);
      for (int v = 0; v < NV; v++)
         run_seq(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
      // R7: start pulse during a run is ignored
      run_seq(30, 36, 3, 0, 1'b1);
      // R5 boundary: lock arrives exactly on the last allowed sample
      run_seq(40, 63, 5, NSET + PMAX - 1, 1'b0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule